// File: doc/BRIEF.md
# Protocol Operation Command Sequencer

This block receives 4-bit host commands, one per write strobe, and decides whether each is legal in the current protocol operation state. A legal command either moves the state machine, arms a change that takes effect at the next end-of-cycle pulse, schedules a one-shot test-symbol request, or sets and clears status flags. An illegal or unknown command writes zero back into the command readback and leaves all state alone.

The block sits between a host register interface and the communication-cycle timing logic, in one clock domain. The timing logic supplies an end-of-cycle pulse and a symbol-window pulse. Startup logic supplies two set strobes for the coldstart noise and abort flags. A test-only force port can place the machine in one of four states, so that every acceptance rule can be reached without running a real startup.

Top module: `opctl_cmd_top`

## Requirements
- R1: After synchronous reset the state output is 0 and the readback is 0. The freeze, halt-request, coldstart-noise and coldstart-abort flags are 0, coldstart-inhibit is 1, single-slot is 1, and the test-symbol request and the RAM-clear pulse are 0. State codes: 0 default-config, 1 config, 2 ready, 3 wakeup, 4 startup, 5 normal-active, 6 normal-passive, 7 halt.
- R2: Command codes are 0011 wakeup, 0100 run, 0101 all-slots, 0110 halt, 0111 freeze, 1000 test-symbol, 1001 allow-coldstart, 1010 clear-status, 1011 clear-RAM. A write with an unlisted code, or with a code that is illegal in the current state, makes the readback 0 on the next cycle and leaves the state unchanged. An accepted write makes the readback equal to its code.
- R3: Wakeup and run are accepted only in ready. They move the state to wakeup or to startup on the next cycle.
- R4: All-slots is accepted only in normal-active or normal-passive. The single-slot output drops to 0 at the next end-of-cycle pulse, not before.
- R5: Halt is accepted only in normal-active or normal-passive. It sets halt-request on the next cycle, and the state becomes halt (7) only at the next end-of-cycle pulse.
- R6: Freeze is accepted in every state. On the next cycle the state is halt and the freeze flag is 1, even while a halt is pending.
- R7: Test-symbol is accepted only in normal-active. After the next end-of-cycle pulse, the first symbol-window pulse produces a one-cycle request whose 2-bit channel mask equals the channel-select bits given with the command. A symbol window before that end of cycle produces no request.
- R8: Allow-coldstart clears coldstart-inhibit in every state except default-config, config and halt, where it is rejected.
- R9: Clear-status is accepted in every state. It clears freeze, halt-request, coldstart-noise and coldstart-abort, and leaves coldstart-inhibit unchanged.
- R10: Clear-RAM is accepted only in default-config or config. It produces a one-cycle RAM-clear pulse on the cycle after the write.
- R11: The force input loads only the codes 1, 2, 5 and 6 into the state. Any other forced code leaves the state unchanged. A command written in the same cycle as a force is dropped.
- R12: The coldstart-noise and coldstart-abort set strobes each set their flag on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_we | input | 1 | Command write strobe |
| cmd_code | input | 4 | Command code written |
| tsym_sel | input | 2 | Channel select bits sampled with a test-symbol command |
| cycle_end | input | 1 | End-of-communication-cycle pulse |
| sym_window | input | 1 | Symbol-window pulse |
| cs_noise_set | input | 1 | Sets the coldstart-noise flag |
| cs_abort_set | input | 1 | Sets the coldstart-abort flag |
| force_en | input | 1 | Test-only state force strobe |
| force_state | input | 3 | State code to force |
| state_o | output | 3 | Current protocol operation state |
| cmd_rdbk | output | 4 | Command field readback |
| flg_freeze | output | 1 | Freeze status flag |
| flg_halt_req | output | 1 | Halt request flag |
| flg_cs_inhibit | output | 1 | Coldstart inhibit flag |
| flg_cs_noise | output | 1 | Coldstart noise flag |
| flg_cs_abort | output | 1 | Coldstart abort flag |
| single_slot | output | 1 | Single-slot mode active |
| tsym_req | output | 1 | One-shot test-symbol request |
| tsym_ch | output | 2 | Channel mask for the test-symbol request |
| ram_clear | output | 1 | One-cycle RAM clear request |

## Verification
A wrong acceptance decision shows on the readback port one cycle after the write, because a rejected code reads back zero while an accepted one echoes its code. An immediate transition that goes wrong shows on the state port in that same cycle. A deferred halt or all-slots change that fires early or never shows in the cycle after the end-of-cycle pulse, so the bench samples both before and after that pulse. A mis-scheduled test symbol shows as a request in the wrong symbol window or with the wrong channel mask, or as a request that does not appear at all.

// File: rtl/opctl_pkg.sv
package opctl_pkg;

    localparam int CMD_W = 4;
    localparam int ST_W  = 3;

    typedef enum logic [ST_W-1:0] {
        ST_DEFCFG  = 3'd0,
        ST_CONFIG  = 3'd1,
        ST_READY   = 3'd2,
        ST_WAKEUP  = 3'd3,
        ST_STARTUP = 3'd4,
        ST_NACT    = 3'd5,
        ST_NPAS    = 3'd6,
        ST_HALT    = 3'd7
    } opst_e;

    typedef enum logic [CMD_W-1:0] {
        OP_NONE    = 4'd0,
        OP_WAKEUP  = 4'd3,
        OP_RUN     = 4'd4,
        OP_ALLSLOT = 4'd5,
        OP_HALT    = 4'd6,
        OP_FREEZE  = 4'd7,
        OP_TSYM    = 4'd8,
        OP_ALLOWCS = 4'd9,
        OP_CLRSTAT = 4'd10,
        OP_CLRRAM  = 4'd11
    } opcmd_e;

    typedef struct packed {
        logic   acc;
        opcmd_e op;
    } cmd_dec_t;

    function automatic logic code_known(logic [CMD_W-1:0] c);
        return (c >= 4'd3) && (c <= 4'd11);
    endfunction

    function automatic logic in_normal(opst_e s);
        return (s == ST_NACT) || (s == ST_NPAS);
    endfunction

    function automatic logic in_cfg(opst_e s);
        return (s == ST_DEFCFG) || (s == ST_CONFIG);
    endfunction

    function automatic logic cmd_legal(opcmd_e op, opst_e s);
        logic ok;
        case (op)
            OP_WAKEUP, OP_RUN:   ok = (s == ST_READY);
            OP_ALLSLOT, OP_HALT: ok = in_normal(s);
            OP_FREEZE, OP_CLRSTAT: ok = 1'b1;
            OP_TSYM:             ok = (s == ST_NACT);
            OP_ALLOWCS:          ok = !(in_cfg(s) || (s == ST_HALT));
            OP_CLRRAM:           ok = in_cfg(s);
            default:             ok = 1'b0;
        endcase
        return ok;
    endfunction

    function automatic logic force_ok(logic [ST_W-1:0] s);
        return (s == ST_CONFIG) || (s == ST_READY) || (s == ST_NACT) || (s == ST_NPAS);
    endfunction

endpackage

// File: rtl/opctl_cmd_gate.sv
module opctl_cmd_gate
    import opctl_pkg::*;
(
    input  logic             cmd_we,
    input  logic [CMD_W-1:0] cmd_code,
    input  opst_e            state,
    output cmd_dec_t         dec
);

    always_comb begin
        dec.acc = 1'b0;
        dec.op  = OP_NONE;
        if (cmd_we && code_known(cmd_code)) begin
            if (cmd_legal(opcmd_e'(cmd_code), state)) begin
                dec.acc = 1'b1;
                dec.op  = opcmd_e'(cmd_code);
            end
        end
    end

endmodule

// File: rtl/opctl_state_seq.sv
module opctl_state_seq
    import opctl_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  cmd_dec_t        dec,
    input  logic            cycle_end,
    input  logic            force_en,
    input  logic [ST_W-1:0] force_state,
    output opst_e           state,
    output logic            single_slot
);

    opst_e state_n;
    logic  halt_pend, halt_pend_n;
    logic  slot_pend, slot_pend_n;
    logic  single_n;

    always_comb begin
        state_n     = state;
        halt_pend_n = halt_pend;
        slot_pend_n = slot_pend;
        single_n    = single_slot;

        if (force_en) begin
            if (force_ok(force_state)) begin
                state_n     = opst_e'(force_state);
                halt_pend_n = 1'b0;
            end
        end else begin
            // deferred work armed in earlier cycles
            if (cycle_end) begin
                if (halt_pend) begin
                    state_n     = ST_HALT;
                    halt_pend_n = 1'b0;
                end
                if (slot_pend) begin
                    single_n    = 1'b0;
                    slot_pend_n = 1'b0;
                end
            end
            if (dec.acc) begin
                case (dec.op)
                    OP_WAKEUP:  state_n = ST_WAKEUP;
                    OP_RUN:     state_n = ST_STARTUP;
                    OP_ALLSLOT: slot_pend_n = 1'b1;
                    OP_HALT:    halt_pend_n = 1'b1;
                    OP_FREEZE: begin
                        state_n     = ST_HALT;
                        halt_pend_n = 1'b0;
                    end
                    default: ;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state       <= ST_DEFCFG;
            halt_pend   <= 1'b0;
            slot_pend   <= 1'b0;
            single_slot <= 1'b1;
        end else begin
            state       <= state_n;
            halt_pend   <= halt_pend_n;
            slot_pend   <= slot_pend_n;
            single_slot <= single_n;
        end
    end

endmodule

// File: rtl/opctl_flag_bank.sv
module opctl_flag_bank
    import opctl_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  cmd_dec_t dec,
    input  logic     cs_noise_set,
    input  logic     cs_abort_set,
    output logic     flg_freeze,
    output logic     flg_halt_req,
    output logic     flg_cs_inhibit,
    output logic     flg_cs_noise,
    output logic     flg_cs_abort
);

    logic clr_stat;
    assign clr_stat = dec.acc && (dec.op == OP_CLRSTAT);

    always_ff @(posedge clk) begin
        if (rst) begin
            flg_freeze     <= 1'b0;
            flg_halt_req   <= 1'b0;
            flg_cs_inhibit <= 1'b1;
            flg_cs_noise   <= 1'b0;
            flg_cs_abort   <= 1'b0;
        end else begin
            if (clr_stat) begin
                flg_freeze   <= 1'b0;
                flg_halt_req <= 1'b0;
                flg_cs_noise <= 1'b0;
                flg_cs_abort <= 1'b0;
            end
            if (dec.acc && dec.op == OP_FREEZE)  flg_freeze     <= 1'b1;
            if (dec.acc && dec.op == OP_HALT)    flg_halt_req   <= 1'b1;
            if (dec.acc && dec.op == OP_ALLOWCS) flg_cs_inhibit <= 1'b0;
            if (cs_noise_set) flg_cs_noise <= 1'b1;
            if (cs_abort_set) flg_cs_abort <= 1'b1;
        end
    end

endmodule

// File: rtl/opctl_tsym_sched.sv
module opctl_tsym_sched
    import opctl_pkg::*;
#(
    parameter int CH_W = 2
) (
    input  logic            clk,
    input  logic            rst,
    input  cmd_dec_t        dec,
    input  logic [CH_W-1:0] tsym_sel,
    input  logic            cycle_end,
    input  logic            sym_window,
    output logic            tsym_req,
    output logic [CH_W-1:0] tsym_ch
);

    logic            armed, live;
    logic [CH_W-1:0] ch_lat;
    logic            fire;

    assign fire = live && sym_window;

    always_ff @(posedge clk) begin
        if (rst) begin
            armed    <= 1'b0;
            live     <= 1'b0;
            ch_lat   <= '0;
            tsym_req <= 1'b0;
            tsym_ch  <= '0;
        end else begin
            tsym_req <= fire;
            tsym_ch  <= fire ? ch_lat : '0;
            if (fire) live <= 1'b0;
            if (armed && cycle_end) begin
                live  <= 1'b1;
                armed <= 1'b0;
            end
            if (dec.acc && dec.op == OP_TSYM) begin
                armed  <= 1'b1;
                ch_lat <= tsym_sel;
            end
        end
    end

endmodule

// File: rtl/opctl_cmd_top.sv
module opctl_cmd_top
    import opctl_pkg::*;
#(
    parameter int CH_W = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cmd_we,
    input  logic [CMD_W-1:0] cmd_code,
    input  logic [CH_W-1:0]  tsym_sel,
    input  logic             cycle_end,
    input  logic             sym_window,
    input  logic             cs_noise_set,
    input  logic             cs_abort_set,
    input  logic             force_en,
    input  logic [ST_W-1:0]  force_state,
    output logic [ST_W-1:0]  state_o,
    output logic [CMD_W-1:0] cmd_rdbk,
    output logic             flg_freeze,
    output logic             flg_halt_req,
    output logic             flg_cs_inhibit,
    output logic             flg_cs_noise,
    output logic             flg_cs_abort,
    output logic             single_slot,
    output logic             tsym_req,
    output logic [CH_W-1:0]  tsym_ch,
    output logic             ram_clear
);

    opst_e    state;
    cmd_dec_t dec;
    logic     we_eff;

    // a force in the same cycle drops the command
    assign we_eff  = cmd_we && !force_en;
    assign state_o = state;

    opctl_cmd_gate u_gate (
        .cmd_we   (we_eff),
        .cmd_code (cmd_code),
        .state    (state),
        .dec      (dec)
    );

    opctl_state_seq u_seq (
        .clk         (clk),
        .rst         (rst),
        .dec         (dec),
        .cycle_end   (cycle_end),
        .force_en    (force_en),
        .force_state (force_state),
        .state       (state),
        .single_slot (single_slot)
    );

    opctl_flag_bank u_flags (
        .clk            (clk),
        .rst            (rst),
        .dec            (dec),
        .cs_noise_set   (cs_noise_set),
        .cs_abort_set   (cs_abort_set),
        .flg_freeze     (flg_freeze),
        .flg_halt_req   (flg_halt_req),
        .flg_cs_inhibit (flg_cs_inhibit),
        .flg_cs_noise   (flg_cs_noise),
        .flg_cs_abort   (flg_cs_abort)
    );

    opctl_tsym_sched #(.CH_W(CH_W)) u_tsym (
        .clk        (clk),
        .rst        (rst),
        .dec        (dec),
        .tsym_sel   (tsym_sel),
        .cycle_end  (cycle_end),
        .sym_window (sym_window),
        .tsym_req   (tsym_req),
        .tsym_ch    (tsym_ch)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_rdbk  <= '0;
            ram_clear <= 1'b0;
        end else begin
            ram_clear <= dec.acc && (dec.op == OP_CLRRAM);
            if (we_eff) cmd_rdbk <= dec.acc ? cmd_code : '0;
        end
    end

endmodule

// File: rtl/opctl_cmd_chk.sv
module opctl_cmd_chk (
    input logic       clk,
    input logic       rst,
    input logic       cmd_we,
    input logic [3:0] cmd_code,
    input logic       cycle_end,
    input logic       sym_window,
    input logic       force_en,
    input logic [2:0] force_state,
    input logic [2:0] state_o,
    input logic [3:0] cmd_rdbk,
    input logic       flg_freeze,
    input logic       flg_halt_req,
    input logic       tsym_req,
    input logic       ram_clear
);

    AST_UNKNOWN_REJ: assert property (@(posedge clk) disable iff (rst)
        (cmd_we && !force_en && (cmd_code < 4'd3 || cmd_code > 4'd11))
        |=> (cmd_rdbk == 4'd0 && state_o == $past(state_o))) else $error("unknown code"); // R2

    AST_WAKE_FROM_READY: assert property (@(posedge clk) disable iff (rst)
        (cmd_we && !force_en && cmd_code == 4'd3 && state_o == 3'd2)
        |=> (state_o == 3'd3)) else $error("wakeup"); // R3

    AST_HALT_REQ_SET: assert property (@(posedge clk) disable iff (rst)
        (cmd_we && !force_en && cmd_code == 4'd6 && (state_o == 3'd5 || state_o == 3'd6))
        |=> flg_halt_req) else $error("halt req"); // R5

    AST_FREEZE_NOW: assert property (@(posedge clk) disable iff (rst)
        (cmd_we && !force_en && cmd_code == 4'd7)
        |=> (state_o == 3'd7 && flg_freeze)) else $error("freeze"); // R6

    AST_TSYM_IN_WINDOW: assert property (@(posedge clk) disable iff (rst)
        tsym_req |-> $past(sym_window)) else $error("tsym window"); // R7

    AST_RAMCLR_SRC: assert property (@(posedge clk) disable iff (rst)
        ram_clear |-> $past(cmd_we && !force_en && cmd_code == 4'd11)) else $error("ram clear"); // R10

    AST_FORCE_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (force_en && !cycle_end && (force_state == 3'd0 || force_state == 3'd3 ||
                                    force_state == 3'd4 || force_state == 3'd7))
        |=> $stable(state_o)) else $error("bad force"); // R11

endmodule

bind opctl_cmd_top opctl_cmd_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .cmd_we      (cmd_we),
    .cmd_code    (cmd_code),
    .cycle_end   (cycle_end),
    .sym_window  (sym_window),
    .force_en    (force_en),
    .force_state (force_state),
    .state_o     (state_o),
    .cmd_rdbk    (cmd_rdbk),
    .flg_freeze  (flg_freeze),
    .flg_halt_req(flg_halt_req),
    .tsym_req    (tsym_req),
    .ram_clear   (ram_clear)
);

// File: tb/opctl_cmd_top_tb_top.sv
module opctl_cmd_top_tb_top;

    localparam int CLK_P = 10;
    localparam int NV    = 19;

    typedef struct packed {
        logic [2:0] st0;
        logic [3:0] code;
        logic [2:0] est;
        logic [3:0] erb;
        logic [3:0] req;
    } vec_t;

    localparam vec_t VECS [NV] = '{
        '{3'd2, 4'd3,  3'd3, 4'd3,  4'd3},   // R3 wakeup from ready
        '{3'd2, 4'd4,  3'd4, 4'd4,  4'd3},   // R3 run from ready
        '{3'd1, 4'd3,  3'd1, 4'd0,  4'd3},   // R3 wakeup rejected in config
        '{3'd5, 4'd4,  3'd5, 4'd0,  4'd3},   // R3 run rejected in normal
        '{3'd1, 4'd5,  3'd1, 4'd0,  4'd4},   // R4 all-slots rejected
        '{3'd5, 4'd5,  3'd5, 4'd5,  4'd4},   // R4 all-slots accepted
        '{3'd6, 4'd6,  3'd6, 4'd6,  4'd5},   // R5 halt deferred
        '{3'd2, 4'd6,  3'd2, 4'd0,  4'd5},   // R5 halt rejected
        '{3'd1, 4'd7,  3'd7, 4'd7,  4'd6},   // R6 freeze from config
        '{3'd6, 4'd8,  3'd6, 4'd0,  4'd7},   // R7 tsym rejected
        '{3'd5, 4'd8,  3'd5, 4'd8,  4'd7},   // R7 tsym accepted
        '{3'd1, 4'd9,  3'd1, 4'd0,  4'd8},   // R8 allow rejected
        '{3'd2, 4'd9,  3'd2, 4'd9,  4'd8},   // R8 allow accepted
        '{3'd1, 4'd10, 3'd1, 4'd10, 4'd9},   // R9 clear-status accepted
        '{3'd1, 4'd11, 3'd1, 4'd11, 4'd10},  // R10 clear-RAM accepted
        '{3'd2, 4'd11, 3'd2, 4'd0,  4'd10},  // R10 clear-RAM rejected
        '{3'd5, 4'd12, 3'd5, 4'd0,  4'd2},   // R2 unknown code
        '{3'd2, 4'd0,  3'd2, 4'd0,  4'd2},   // R2 zero code
        '{3'd6, 4'd15, 3'd6, 4'd0,  4'd2}    // R2 top code
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cmd_we = 1'b0;
    logic [3:0] cmd_code = '0;
    logic [1:0] tsym_sel = '0;
    logic       cycle_end = 1'b0;
    logic       sym_window = 1'b0;
    logic       cs_noise_set = 1'b0;
    logic       cs_abort_set = 1'b0;
    logic       force_en = 1'b0;
    logic [2:0] force_state = '0;
    logic [2:0] state_o;
    logic [3:0] cmd_rdbk;
    logic       flg_freeze, flg_halt_req, flg_cs_inhibit, flg_cs_noise, flg_cs_abort;
    logic       single_slot, tsym_req, ram_clear;
    logic [1:0] tsym_ch;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    opctl_cmd_top dut_i (
        .clk(clk), .rst(rst), .cmd_we(cmd_we), .cmd_code(cmd_code),
        .tsym_sel(tsym_sel), .cycle_end(cycle_end), .sym_window(sym_window),
        .cs_noise_set(cs_noise_set), .cs_abort_set(cs_abort_set),
        .force_en(force_en), .force_state(force_state),
        .state_o(state_o), .cmd_rdbk(cmd_rdbk),
        .flg_freeze(flg_freeze), .flg_halt_req(flg_halt_req),
        .flg_cs_inhibit(flg_cs_inhibit), .flg_cs_noise(flg_cs_noise),
        .flg_cs_abort(flg_cs_abort), .single_slot(single_slot),
        .tsym_req(tsym_req), .tsym_ch(tsym_ch), .ram_clear(ram_clear)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // all tasks start and end at a falling edge
    task automatic force_to(input logic [2:0] s);
        force_en = 1'b1; force_state = s;
        @(negedge clk);
        force_en = 1'b0;
    endtask

    task automatic issue(input logic [3:0] c, input logic [1:0] sel);
        cmd_we = 1'b1; cmd_code = c; tsym_sel = sel;
        @(negedge clk);
        cmd_we = 1'b0; cmd_code = '0; tsym_sel = '0;
    endtask

    task automatic pulse_end();
        cycle_end = 1'b1;
        @(negedge clk);
        cycle_end = 1'b0;
    endtask

    task automatic pulse_sym();
        sym_window = 1'b1;
        @(negedge clk);
        sym_window = 1'b0;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        #(CLK_P * 50000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog (R1..R12 run) actual=hung expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        do_reset();
        // R1 reset values
        chk("R1 state", 32'(state_o), 32'd0);
        chk("R1 rdbk", 32'(cmd_rdbk), 32'd0);
        chk("R1 flags", {27'd0, flg_freeze, flg_halt_req, flg_cs_inhibit, flg_cs_noise, flg_cs_abort}, 32'b00100);
        chk("R1 single", 32'(single_slot), 32'd1);
        chk("R1 outs", {30'd0, tsym_req, ram_clear}, 32'd0);

        // acceptance table
        for (int i = 0; i < NV; i++) begin
            force_to(VECS[i].st0);
            issue(VECS[i].code, 2'b00);
            chk($sformatf("R%0d vec%0d state", VECS[i].req, i), 32'(state_o), 32'(VECS[i].est));
            chk($sformatf("R%0d vec%0d rdbk", VECS[i].req, i), 32'(cmd_rdbk), 32'(VECS[i].erb));
        end

        do_reset();
        // R12 set strobes
        cs_noise_set = 1'b1; cs_abort_set = 1'b1;
        @(negedge clk);
        cs_noise_set = 1'b0; cs_abort_set = 1'b0;
        chk("R12 noise", 32'(flg_cs_noise), 32'd1);
        chk("R12 abort", 32'(flg_cs_abort), 32'd1);
        // R9 clear-status keeps inhibit
        issue(4'd10, 2'b00);
        chk("R9 noise/abort", {30'd0, flg_cs_noise, flg_cs_abort}, 32'd0);
        chk("R9 inhibit kept", 32'(flg_cs_inhibit), 32'd1);
        // R10 one-cycle pulse
        issue(4'd11, 2'b00);
        chk("R10 pulse", 32'(ram_clear), 32'd1);
        @(negedge clk);
        chk("R10 pulse end", 32'(ram_clear), 32'd0);
        // R11 force filtering
        force_to(3'd7);
        chk("R11 force halt ignored", 32'(state_o), 32'd0);
        force_to(3'd4);
        chk("R11 force startup ignored", 32'(state_o), 32'd0);
        force_to(3'd1);
        chk("R11 force config", 32'(state_o), 32'd1);
        // R8 allow coldstart in ready
        force_to(3'd2);
        issue(4'd9, 2'b00);
        chk("R8 inhibit cleared", 32'(flg_cs_inhibit), 32'd0);
        // R4 deferred single-slot exit
        force_to(3'd5);
        issue(4'd5, 2'b00);
        chk("R4 before end", 32'(single_slot), 32'd1);
        pulse_end();
        chk("R4 after end", 32'(single_slot), 32'd0);
        // R7 test symbol scheduling
        issue(4'd8, 2'b10);
        pulse_sym();
        chk("R7 early window", 32'(tsym_req), 32'd0);
        pulse_end();
        pulse_sym();
        chk("R7 req", 32'(tsym_req), 32'd1);
        chk("R7 channels", 32'(tsym_ch), 32'd2);
        @(negedge clk);
        chk("R7 one shot", 32'(tsym_req), 32'd0);
        force_to(3'd6);
        issue(4'd8, 2'b01);
        pulse_end();
        pulse_sym();
        chk("R7 rejected passive", 32'(tsym_req), 32'd0);
        // R5 deferred halt
        issue(4'd6, 2'b00);
        chk("R5 halt req", 32'(flg_halt_req), 32'd1);
        chk("R5 still passive", 32'(state_o), 32'd6);
        pulse_end();
        chk("R5 halted", 32'(state_o), 32'd7);
        issue(4'd10, 2'b00);
        chk("R9 halt req cleared", 32'(flg_halt_req), 32'd0);
        // R6 freeze over pending halt
        force_to(3'd5);
        issue(4'd6, 2'b00);
        chk("R6 pending", 32'(state_o), 32'd5);
        issue(4'd7, 2'b00);
        chk("R6 state", 32'(state_o), 32'd7);
        chk("R6 freeze flag", 32'(flg_freeze), 32'd1);
        issue(4'd10, 2'b00);
        chk("R9 freeze cleared", 32'(flg_freeze), 32'd0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule